// File: doc/BRIEF.md
# Test-Mode ROM Dump Controller

This block gives production test access to a small controller's program store. Three level inputs report which of the reset, test and program pins are held at the raised test level. While the logic-level reset pin is asserted, the block decodes these three inputs into one of four modes and latches the result. When the reset pin is released, the block runs in the latched mode until the next reset.

In the free-running dump mode, the program counter starts at zero. Each machine cycle places the next internal ROM word on the address/data port, one clock after the address-latch strobe rises. The stepped dump mode shows word zero once and then waits. Each falling edge of an asynchronous step strobe advances the counter and shows the next word. In the external-execution mode, the block drives the low byte of the counter onto the port while the address-latch strobe is high. It then releases the port and, at the end of the cycle, captures the external memory byte together with an opcode byte presented on an auxiliary port. The counter stays within one 256-byte page. Normal mode leaves the ports untouched.

Top module: `tmd_dump_ctl`

## Requirements
- R1: After `rst`, all outputs are zero and `mode_o` is 0. In normal mode, `ale`, `ad_oe` and `fetch_vld` stay low and `ad_out` stays zero.
- R2: The mode is decoded as follows. `hv_rst` low gives 0 (normal). `hv_rst`, `hv_prg` and `hv_tst` all high give 1 (free dump). `hv_rst` and `hv_prg` high with `hv_tst` low give 2 (stepped dump). `hv_rst` high with `hv_prg` low gives 3 (external execution), whatever `hv_tst` is.
- R3: `mode_o` loads the decoded value only on clocks where `rst_pin` is high. On any other clock it holds, whatever the `hv_*` inputs do.
- R4: While `rst_pin` is high, the counter is 0 and `ale` and `ad_oe` are low. After release, a machine cycle lasts CYC clocks (default 4), and `ale` is high for exactly one clock, the second clock of the cycle. In free dump and external modes, machine cycles run back to back.
- R5: In free dump mode, `ad_oe` is high. `ad_out` takes the next ROM word on the same clock edge where `ale` falls. The first word is from address 0, and the address rises by one each machine cycle.
- R6: In stepped dump mode, one machine cycle shows address 0 after release, and then no `ale` pulse occurs. Each falling edge of `step_strobe` is passed through two synchronising flops and one edge flop. It then increments the counter and runs one machine cycle that shows the new word.
- R7: In external mode, `ad_out` carries the counter's low 8 bits with `ad_oe` high during the `ale` clock, and `ad_oe` is low afterwards. At the last clock of the cycle, `ad_in` is captured into `fetch_q` and `aux_in` into `op_q`, and `fetch_vld` pulses high for one clock.
- R8: In external mode, the counter steps from 255 back to 0, and its bits above bit 7 stay zero.
- R9: In free dump mode, the counter steps from the last ROM address (2^AW-1, default 1023) back to 0.
- R10: The ROM word at address a equals ((a*29) XOR (a>>3) XOR 0xA5) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_pin | input | 1 | Reset pin at logic level; mode capture and counter clear |
| hv_rst | input | 1 | Reset pin seen at raised test level |
| hv_tst | input | 1 | Test pin seen at raised test level |
| hv_prg | input | 1 | Program pin seen at raised test level |
| step_strobe | input | 1 | Asynchronous strobe; falling edge steps the stepped dump |
| ad_in | input | DW | Address/data port input (external memory data) |
| aux_in | input | DW | Auxiliary port input (opcode bytes) |
| ad_out | output | DW | Address/data port output value |
| ad_oe | output | 1 | Address/data port output enable |
| ale | output | 1 | Address-latch strobe |
| fetch_q | output | DW | Byte fetched from external memory |
| op_q | output | DW | Opcode byte sampled on the auxiliary port |
| fetch_vld | output | 1 | One-clock pulse marking a new fetch |
| mode_o | output | 2 | Latched mode: 0 normal, 1 free, 2 stepped, 3 external |
| pc_o | output | AW | Current program counter |

## Verification
The checks rely on three assumptions about the inputs. The `hv_*` levels are meaningful only while `rst_pin` is high. Strobe falling edges arrive while a stepped cycle is idle. No strobe edge lands in the clock where a cycle starts. The stimulus changes mode inputs only inside a `rst_pin` window, except for the deliberate hold test. It holds each strobe level for twelve clocks, which is longer than a sync delay plus a machine cycle. External memory and opcode bytes come from an address latch driven by `ale`, so the fetched bytes depend only on the address the block presented.

// File: rtl/tmd_pkg.sv
package tmd_pkg;

  typedef enum logic [1:0] {
    MD_NORMAL = 2'd0,
    MD_FREE   = 2'd1,
    MD_STEP   = 2'd2,
    MD_EXT    = 2'd3
  } tmd_mode_e;

  // Program store contents, generated from the address.
  function automatic logic [7:0] rom_word(input int a);
    logic [7:0] r;
    r = 8'(a * 29) ^ 8'(a >> 3) ^ 8'hA5;
    return r;
  endfunction

endpackage

// File: rtl/tmd_strobe_sync.sv
module tmd_strobe_sync (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic fall_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= strobe_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign fall_o = s3 & ~s2;

  // R6: a single strobe edge yields a single step event
  a_r6_fall_single: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);

endmodule

// File: rtl/tmd_rom.sv
module tmd_rom #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(tmd_pkg::rom_word(i));
  end

  always_ff @(posedge clk) q <= mem[addr];

endmodule

// File: rtl/tmd_mode_sel.sv
module tmd_mode_sel
  import tmd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic      hv_rst,
  input  logic      hv_tst,
  input  logic      hv_prg,
  output tmd_mode_e mode_o
);
  tmd_mode_e dec;

  always_comb begin
    if (!hv_rst)      dec = MD_NORMAL;
    else if (!hv_prg) dec = MD_EXT;
    else if (hv_tst)  dec = MD_FREE;
    else              dec = MD_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst)       mode_o <= MD_NORMAL;
    else if (load) mode_o <= dec;
  end

  // R3: mode frozen outside the reset-pin window
  a_r3_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(mode_o));

endmodule

// File: rtl/tmd_dump_ctl.sv
module tmd_dump_ctl
  import tmd_pkg::*;
#(
  parameter int AW      = 10,
  parameter int DW      = 8,
  parameter int CYC     = 4,
  parameter int PAGE_AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rst_pin,
  input  logic          hv_rst,
  input  logic          hv_tst,
  input  logic          hv_prg,
  input  logic          step_strobe,
  input  logic [DW-1:0] ad_in,
  input  logic [DW-1:0] aux_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          ale,
  output logic [DW-1:0] fetch_q,
  output logic [DW-1:0] op_q,
  output logic          fetch_vld,
  output logic [1:0]    mode_o,
  output logic [AW-1:0] pc_o
);
  localparam int            PW      = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(CYC - 1);
  localparam logic [PW-1:0] PH_ALE  = PW'(1);

  tmd_mode_e            mode;
  logic [PW-1:0]        ph;
  logic                 busy;
  logic [AW-1:0]        pc;
  logic [DW-1:0]        rom_q;
  logic                 fall;
  logic                 step_evt;
  logic                 is_dump;
  logic [PAGE_AW-1:0]   pg_next;

  tmd_mode_sel u_sel (
    .clk(clk), .rst(rst), .load(rst_pin),
    .hv_rst(hv_rst), .hv_tst(hv_tst), .hv_prg(hv_prg),
    .mode_o(mode)
  );

  tmd_strobe_sync u_sync (
    .clk(clk), .rst(rst), .strobe_i(step_strobe), .fall_o(fall)
  );

  tmd_rom #(.AW(AW), .DW(DW)) u_rom (
    .clk(clk), .addr(pc), .q(rom_q)
  );

  assign step_evt = !rst_pin && (mode == MD_STEP) && fall;
  assign is_dump  = (mode == MD_FREE) || (mode == MD_STEP);
  assign pg_next  = pc[PAGE_AW-1:0] + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      busy      <= 1'b0;
      pc        <= '0;
      ale       <= 1'b0;
      ad_oe     <= 1'b0;
      ad_out    <= '0;
      fetch_q   <= '0;
      op_q      <= '0;
      fetch_vld <= 1'b0;
    end else if (rst_pin) begin
      ph        <= '0;
      busy      <= 1'b1;
      pc        <= '0;
      ale       <= 1'b0;
      ad_oe     <= 1'b0;
      ad_out    <= '0;
      fetch_vld <= 1'b0;
    end else begin
      fetch_vld <= 1'b0;
      ale       <= 1'b0;
      if (mode != MD_NORMAL) begin
        ale <= busy && (ph == '0) && !step_evt;
        // sequencing of the machine cycle
        if (step_evt) begin
          pc   <= pc + 1'b1;
          ph   <= '0;
          busy <= 1'b1;
        end else if (busy) begin
          if (ph == PH_LAST) begin
            ph <= '0;
            case (mode)
              MD_FREE: pc <= pc + 1'b1;
              MD_STEP: busy <= 1'b0;
              MD_EXT: begin
                pc        <= AW'(pg_next);
                fetch_q   <= ad_in;
                op_q      <= aux_in;
                fetch_vld <= 1'b1;
              end
              default: ;
            endcase
          end else begin
            ph <= ph + 1'b1;
          end
        end
        // port drive
        if (is_dump) begin
          ad_oe <= 1'b1;
          if (busy && !step_evt && ph == PH_ALE) ad_out <= rom_q;
        end else if (busy && !step_evt) begin
          if (ph == '0) begin
            ad_out <= DW'(pc[PAGE_AW-1:0]);
            ad_oe  <= 1'b1;
          end else if (ph == PH_ALE) begin
            ad_oe  <= 1'b0;
          end
        end
      end
    end
  end

  assign mode_o = mode;
  assign pc_o   = pc;

  // R1: normal mode leaves the port and strobes idle
  a_r1_normal_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_NORMAL) |-> (!ale && !ad_oe && !fetch_vld));

  // R4: address-latch strobe lasts one clock
  a_r4_ale_single: assert property (@(posedge clk) disable iff (rst)
    $rose(ale) |=> !ale);

  // R6: each synchronised strobe edge advances the counter by one
  a_r6_step_advance: assert property (@(posedge clk) disable iff (rst || rst_pin)
    step_evt |=> (pc == AW'($past(pc) + 1'b1)));

  // R7: the port is released when the fetched byte is taken
  a_r7_bus_turn: assert property (@(posedge clk) disable iff (rst)
    fetch_vld |-> !ad_oe);

  // R8: external execution stays inside one page
  a_r8_page_bound: assert property (@(posedge clk) disable iff (rst)
    (mode == MD_EXT) |-> (pc[AW-1:PAGE_AW] == '0));

  // R9: free dump wraps at the end of the store
  a_r9_rom_wrap: assert property (@(posedge clk) disable iff (rst || rst_pin)
    ((mode == MD_FREE) && busy && (ph == PH_LAST) && (&pc)) |=> (pc == '0));

endmodule

// File: tb/tmd_dump_ctl_bench.sv
module tmd_dump_ctl_bench;
  localparam int AW  = 10;
  localparam int DW  = 8;
  localparam int CYC = 4;

  logic clk = 1'b0;
  logic rst, rst_pin, hv_rst, hv_tst, hv_prg, step_strobe;
  logic [DW-1:0] ad_in, aux_in, ad_out, fetch_q, op_q;
  logic ad_oe, ale, fetch_vld;
  logic [1:0] mode_o;
  logic [AW-1:0] pc_o;

  always #10 clk = ~clk;

  tmd_dump_ctl #(.AW(AW), .DW(DW), .CYC(CYC)) u_tmd_dump_ctl (
    .clk(clk), .rst(rst), .rst_pin(rst_pin), .hv_rst(hv_rst), .hv_tst(hv_tst),
    .hv_prg(hv_prg), .step_strobe(step_strobe), .ad_in(ad_in), .aux_in(aux_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .fetch_q(fetch_q), .op_q(op_q),
    .fetch_vld(fetch_vld), .mode_o(mode_o), .pc_o(pc_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int bmode = 0;           // mode the bench has selected
  string tag = "R5";
  int exp_q[$];
  int last_addr = 0;
  int n_fetch = 0;
  int norm_bad = 0;
  int since = 0;
  bit have_prev = 0;
  bit ale_d = 0;
  logic [7:0] lat = 8'h00;

  function automatic logic [7:0] rom_exp(input int a);
    return 8'(a * 29) ^ 8'(a >> 3) ^ 8'hA5;
  endfunction

  function automatic logic [7:0] ext_byte(input int a);
    return 8'(a * 3 + 23);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // external memory model: address latched while ale is high
  always @(negedge clk) if (ale) lat <= ad_out;
  assign ad_in  = ext_byte(int'(lat));
  assign aux_in = ~lat;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !rst_pin) begin
      if (bmode == 0 && (ale || ad_oe || fetch_vld || ad_out != 0)) norm_bad++;
      since++;
      if (ale && !ale_d) begin
        if (have_prev && (bmode == 1 || bmode == 3)) chk(since == CYC, "R4 cycle length", since, CYC);
        have_prev = 1;
        since = 0;
      end
      if (bmode == 3) begin
        if (ale) begin
          if (exp_q.size() == 0) chk(0, "R7 unexpected address phase", int'(ad_out), -1);
          else begin
            int e;
            e = exp_q.pop_front();
            last_addr = e % 256;
            chk(ad_oe && ad_out == 8'(last_addr), (e >= 256) ? "R8 page wrap" : "R7 address out",
                int'(ad_out), last_addr);
          end
        end
        if (fetch_vld) begin
          n_fetch++;
          chk(fetch_q == ext_byte(last_addr), "R7 fetch byte", int'(fetch_q), int'(ext_byte(last_addr)));
          chk(op_q == ~8'(last_addr), "R7 opcode byte", int'(op_q), int'(~8'(last_addr)));
        end
      end else if (ale_d && !ale) begin
        if (exp_q.size() == 0) chk(0, {tag, " unexpected dump word"}, int'(ad_out), -1);
        else begin
          int e, a;
          e = exp_q.pop_front();
          a = e % (1 << AW);
          chk(ad_oe && ad_out == rom_exp(a), (e >= (1 << AW)) ? "R9 wrap R10" : {tag, " R10 word"},
              int'(ad_out), int'(rom_exp(a)));
        end
      end
    end
    ale_d = ale;
  end

  task automatic enter_mode(input bit r, input bit t, input bit p, input int m, input string req);
    @(negedge clk);
    rst_pin = 1; hv_rst = r; hv_tst = t; hv_prg = p;
    repeat (3) @(negedge clk);
    chk(mode_o == 2'(m), req, int'(mode_o), m);
    chk(!ale && !ad_oe && pc_o == 0, "R4 held in reset pin", int'(pc_o), 0);
    bmode = m; have_prev = 0;
  endtask

  task automatic wait_empty();
    do begin @(negedge clk); #1; end while (exp_q.size() != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; rst_pin = 0; hv_rst = 0; hv_tst = 0; hv_prg = 0; step_strobe = 1;
    repeat (4) @(negedge clk);
    chk(mode_o == 0 && !ale && !ad_oe && ad_out == 0 && !fetch_vld && fetch_q == 0 && op_q == 0,
        "R1 reset state", int'(mode_o), 0);
    rst = 0;

    // normal mode, then a select change with the reset pin low (R1, R3)
    enter_mode(0, 0, 0, 0, "R2 normal decode");
    enter_mode(0, 1, 0, 0, "R2 test-only is normal");
    rst_pin = 0;
    repeat (40) @(negedge clk);
    hv_rst = 1; hv_tst = 1; hv_prg = 1;
    repeat (10) @(negedge clk);
    chk(mode_o == 0, "R3 select ignored while running", int'(mode_o), 0);
    chk(norm_bad == 0, "R1 normal mode quiet", norm_bad, 0);

    // free dump through the end of the store (R5, R9, R10)
    enter_mode(1, 1, 1, 1, "R2 free decode");
    tag = "R5";
    for (int i = 0; i < (1 << AW) + 6; i++) exp_q.push_back(i);
    rst_pin = 0;
    wait_empty();
    rst_pin = 1;

    // stepped dump (R6)
    enter_mode(1, 0, 1, 2, "R2 step decode");
    tag = "R6";
    exp_q.push_back(0);
    rst_pin = 0;
    wait_empty();
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0 && !ale, "R6 idle without strobe", int'(ale), 0);
    for (int k = 1; k <= 20; k++) begin
      exp_q.push_back(k);
      step_strobe = 0;
      repeat (12) @(negedge clk);
      step_strobe = 1;
      repeat (12) @(negedge clk);
    end
    wait_empty();
    chk(pc_o == 20, "R6 step count", int'(pc_o), 20);

    // external execution with page wrap (R7, R8)
    enter_mode(1, 1, 0, 3, "R2 ext decode with test high");
    enter_mode(1, 0, 0, 3, "R2 ext decode");
    for (int i = 0; i < 262; i++) exp_q.push_back(i);
    n_fetch = 0;
    rst_pin = 0;
    repeat (20) @(negedge clk);
    hv_rst = 0; hv_prg = 1;
    repeat (4) @(negedge clk);
    chk(mode_o == 3, "R3 mode held in external run", int'(mode_o), 3);
    do begin @(negedge clk); #1; end while (n_fetch < 262);
    rst_pin = 1;
    chk(exp_q.size() == 0, "R8 all addresses seen", exp_q.size(), 0);

    // back to normal
    enter_mode(0, 0, 0, 0, "R2 return to normal");
    rst_pin = 0;
    norm_bad = 0;
    repeat (30) @(negedge clk);
    chk(norm_bad == 0, "R1 normal quiet after test", norm_bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule